// File: doc/BRIEF.md
# Flagged Byte Port for an Accumulator Machine

This block sits between an accumulator-based processor and two byte-wide devices. A source device delivers bytes into an inbound holding register. The processor drains that register with a read command. The processor fills an outbound holding register from the low byte of its accumulator with a write command, and a sink device drains it through a valid/ready handshake.

Each holding register has a status flag, and the two flags start from opposite states. The inbound flag starts clear, meaning nothing is waiting. The outbound flag starts set, meaning the register is free to take a byte. The processor can poll either flag with a skip-test command, which answers in the same cycle. It can also turn on an interrupt enable, and the block then raises a registered interrupt request whenever either flag asks for service.

Top module: `byte_port_if`

## Requirements
- R1: After reset the inbound flag is clear (`dev_in_ready` = 1), the outbound flag is set (`dev_out_valid` = 0), the interrupt enable is off and `irq_o` = 0.
- R2: A byte offered on `dev_in_valid`/`dev_in_data` while `dev_in_ready` is 1 is stored and sets the inbound flag. From the next cycle `dev_in_ready` is 0. Further offered bytes are refused and the stored byte is kept until it is read.
- R3: With `cmd_valid` = 1 and `cmd_op` = 1 (skip-if-inbound), `skip_o` is 1 in that same cycle exactly when the inbound flag is set. `skip_o` is 0 whenever no skip command is presented.
- R4: With `cmd_valid` = 1 and `cmd_op` = 2 (skip-if-outbound), `skip_o` is 1 in that same cycle exactly when the outbound flag is set.
- R5: With `cmd_valid` = 1 and `cmd_op` = 3 (read), `rd_data_o` shows the stored inbound byte in that cycle. The inbound flag clears at the clock edge, so `dev_in_ready` is 1 from the next cycle.
- R6: With `cmd_valid` = 1 and `cmd_op` = 4 (write) while the outbound flag is set, bits [7:0] of `acc_i` are loaded and the outbound flag clears. From the next cycle `dev_out_valid` = 1 and `dev_out_data` holds that byte.
- R7: A write command issued while the outbound flag is clear has no effect. The byte already on `dev_out_data` is kept.
- R8: While `dev_out_valid` = 1 and `dev_out_ready` = 0, `dev_out_valid` and `dev_out_data` hold steady. A cycle with both high completes the transfer, and `dev_out_valid` is 0 from the next cycle.
- R9: `cmd_op` = 5 sets the interrupt enable and `cmd_op` = 6 clears it (both with `cmd_valid` = 1). While the enable is off, `irq_o` is 0 from one cycle after the clearing edge.
- R10: `irq_o` is a register that, at each edge, takes enable AND (inbound flag OR outbound flag) as they stood before that edge. It therefore follows a flag or enable change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | Command code (0 none, 1 skip-in, 2 skip-out, 3 read, 4 write, 5 irq on, 6 irq off) |
| acc_i | input | ACC_W (16) | Processor accumulator; low byte is used by write |
| skip_o | output | 1 | Skip-test answer for the current command |
| rd_data_o | output | DATA_W (8) | Stored inbound byte, taken by read |
| dev_in_valid | input | 1 | Source device offers a byte |
| dev_in_data | input | DATA_W (8) | Offered byte |
| dev_in_ready | output | 1 | Inbound register can take a byte |
| dev_out_valid | output | 1 | Outbound byte waiting for the sink |
| dev_out_data | output | DATA_W (8) | Outbound byte |
| dev_out_ready | input | 1 | Sink takes the byte this cycle |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume one command per cycle and a `cmd_op` that is one of the listed codes. They also assume the processor obeys the flags in a normal program, although a write to a busy register is allowed on purpose to exercise R7. The bench holds a source byte on the inbound port across refused cycles and drops it before the read, so no byte is offered in the cycle the flag clears. It toggles the sink's ready only between edges, so every stall and every completed transfer is a deliberate one that the scoreboard expects.

// File: rtl/byte_port_pkg.sv
package byte_port_pkg;

  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_SKIP_IN   = 3'd1,
    CMD_SKIP_OUT  = 3'd2,
    CMD_READ_IN   = 3'd3,
    CMD_WRITE_OUT = 3'd4,
    CMD_IRQ_ON    = 3'd5,
    CMD_IRQ_OFF   = 3'd6,
    CMD_SPARE     = 3'd7
  } port_cmd_e;

endpackage

// File: rtl/inbox_reg.sv
module inbox_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              take,
  output logic              full_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept = src_valid & ~full_q;

  always_comb begin
    full_d = full_q;
    if (take)   full_d = 1'b0;
    if (accept) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (accept) data_q <= src_data;
  end

  assign full_o  = full_q;
  assign ready_o = ~full_q;
  assign data_o  = data_q;

  AST_IN_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && ready_o) |=> !ready_o); // R2

  AST_IN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(data_o))); // R2

  AST_IN_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !src_valid) |=> ready_o); // R5

endmodule

// File: rtl/outbox_reg.sv
module outbox_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sink_ready,
  output logic              empty_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  logic              empty_q, empty_d;
  logic [DATA_W-1:0] data_q;
  logic              load_ok, drain;

  assign load_ok = load & empty_q;
  assign drain   = ~empty_q & sink_ready;

  always_comb begin
    empty_d = empty_q;
    if (load_ok)    empty_d = 1'b0;
    else if (drain) empty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b1;
    else        empty_q <= empty_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_ok) data_q <= load_data;
  end

  assign empty_o = empty_q;
  assign valid_o = ~empty_q;
  assign data_o  = data_q;

  AST_OUT_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (load && valid_o) |=> $stable(data_o)); // R7

  AST_OUT_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !sink_ready) |=> (valid_o && $stable(data_o))); // R8

  AST_OUT_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && sink_ready) |=> !valid_o); // R8

  AST_OUT_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !valid_o) |=> (valid_o && data_o == $past(load_data))); // R6

endmodule

// File: rtl/irq_gen.sv
module irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic en_clr,
  input  logic in_full,
  input  logic out_empty,
  output logic irq_o
);

  logic ien_q, ien_d;
  logic irq_q, irq_d;

  always_comb begin
    ien_d = ien_q;
    if (en_set)      ien_d = 1'b1;
    else if (en_clr) ien_d = 1'b0;
    irq_d = ien_q & (in_full | out_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ien_q <= ien_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |=> !irq_o); // R9

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q && (in_full || out_empty)) |=> irq_o); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_full && !out_empty) |=> !irq_o); // R10

endmodule

// File: rtl/byte_port_if.sv
module byte_port_if
  import byte_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ACC_W-1:0]  acc_i,
  output logic              skip_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  output logic              irq_o
);

  localparam int HI_W = ACC_W - DATA_W;

  port_cmd_e op;
  logic      do_skip_in, do_skip_out, do_read, do_write, do_ien_on, do_ien_off;
  logic      in_full, out_empty;
  logic [HI_W-1:0] unused_acc_hi;

  assign op            = port_cmd_e'(cmd_op);
  assign unused_acc_hi = acc_i[ACC_W-1:DATA_W];

  always_comb begin
    do_skip_in  = 1'b0;
    do_skip_out = 1'b0;
    do_read     = 1'b0;
    do_write    = 1'b0;
    do_ien_on   = 1'b0;
    do_ien_off  = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        CMD_SKIP_IN:   do_skip_in  = 1'b1;
        CMD_SKIP_OUT:  do_skip_out = 1'b1;
        CMD_READ_IN:   do_read     = 1'b1;
        CMD_WRITE_OUT: do_write    = 1'b1;
        CMD_IRQ_ON:    do_ien_on   = 1'b1;
        CMD_IRQ_OFF:   do_ien_off  = 1'b1;
        default: ;
      endcase
    end
  end

  inbox_reg #(.DATA_W(DATA_W)) u_inbox (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (dev_in_valid),
    .src_data  (dev_in_data),
    .take      (do_read),
    .full_o    (in_full),
    .ready_o   (dev_in_ready),
    .data_o    (rd_data_o)
  );

  outbox_reg #(.DATA_W(DATA_W)) u_outbox (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (do_write),
    .load_data  (acc_i[DATA_W-1:0]),
    .sink_ready (dev_out_ready),
    .empty_o    (out_empty),
    .valid_o    (dev_out_valid),
    .data_o     (dev_out_data)
  );

  irq_gen u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_set    (do_ien_on),
    .en_clr    (do_ien_off),
    .in_full   (in_full),
    .out_empty (out_empty),
    .irq_o     (irq_o)
  );

  assign skip_o = (do_skip_in & in_full) | (do_skip_out & out_empty);

  AST_SKIP_ONLY_ON_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> (cmd_valid && (op == CMD_SKIP_IN || op == CMD_SKIP_OUT))); // R3

  AST_SKIPOUT_MATCHES_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == CMD_SKIP_OUT) |-> (skip_o == !dev_out_valid)); // R4

  AST_SKIPIN_MATCHES_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == CMD_SKIP_IN) |-> (skip_o == !dev_in_ready)); // R3

endmodule

// File: tb/tb_byte_port_if.sv
module tb_byte_port_if;
  import byte_port_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [15:0] acc_i;
  logic        skip_o;
  logic [7:0]  rd_data_o;
  logic        dev_in_valid;
  logic [7:0]  dev_in_data;
  logic        dev_in_ready;
  logic        dev_out_valid;
  logic [7:0]  dev_out_data;
  logic        dev_out_ready;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] in_q[$];
  logic [7:0] out_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_port_if dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .acc_i(acc_i),
    .skip_o(skip_o), .rd_data_o(rd_data_o), .dev_in_valid(dev_in_valid),
    .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready), .irq_o(irq_o)
  );

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_cmd(input port_cmd_e op, input logic [15:0] acc);
    cmd_valid = 1'b1;
    cmd_op    = op;
    acc_i     = acc;
    #1;
    if (op == CMD_READ_IN) begin
      if (in_q.size() == 0) check(16'h1, 16'h0, "R5 read with empty scoreboard");
      else check({8'h0, rd_data_o}, {8'h0, in_q.pop_front()}, "R5 read data");
    end
    tick();
    cmd_valid = 1'b0;
    cmd_op    = CMD_NONE;
  endtask

  task automatic skip_test(input port_cmd_e op, input logic exp, input string tag);
    cmd_valid = 1'b1;
    cmd_op    = op;
    #1;
    check({15'h0, skip_o}, {15'h0, exp}, tag);
    tick();
    cmd_valid = 1'b0;
    cmd_op    = CMD_NONE;
  endtask

  // Sink monitor: compares each completed transfer with the scoreboard.
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n === 1'b1 && dev_out_valid && dev_out_ready) begin
      if (out_q.size() == 0) check(16'h1, 16'h0, "R8 unexpected sink transfer");
      else check({8'h0, dev_out_data}, {8'h0, out_q.pop_front()}, "R6 sink byte");
    end
  end

  task automatic run_all();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = CMD_NONE; acc_i = '0;
    dev_in_valid = 1'b0; dev_in_data = '0; dev_out_ready = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check({15'h0, dev_in_ready},  16'h1, "R1 inbound flag clear");
    check({15'h0, dev_out_valid}, 16'h0, "R1 outbound flag set");
    check({15'h0, irq_o},         16'h0, "R1 irq low");
    check({15'h0, skip_o},        16'h0, "R3 no skip without command");

    skip_test(CMD_SKIP_IN,  1'b0, "R3 skip-in empty");
    skip_test(CMD_SKIP_OUT, 1'b1, "R4 skip-out free");

    // R2: accept one byte, refuse the next
    dev_in_valid = 1'b1; dev_in_data = 8'hA5; in_q.push_back(8'hA5);
    tick();
    check({15'h0, dev_in_ready}, 16'h0, "R2 ready drops after accept");
    dev_in_data = 8'h3C;
    tick();
    tick();
    check({15'h0, dev_in_ready}, 16'h0, "R2 second byte refused");
    dev_in_valid = 1'b0;
    skip_test(CMD_SKIP_IN, 1'b1, "R3 skip-in full");
    do_cmd(CMD_READ_IN, 16'h0);
    check({15'h0, dev_in_ready}, 16'h1, "R5 flag cleared by read");
    skip_test(CMD_SKIP_IN, 1'b0, "R3 skip-in after read");

    // R6/R7/R8: write, busy write, stall, drain
    out_q.push_back(8'h34);
    do_cmd(CMD_WRITE_OUT, 16'h1234);
    check({15'h0, dev_out_valid}, 16'h1, "R6 valid after write");
    check({8'h0, dev_out_data},   16'h0034, "R6 low byte loaded");
    skip_test(CMD_SKIP_OUT, 1'b0, "R4 skip-out busy");
    do_cmd(CMD_WRITE_OUT, 16'h00FF);
    check({8'h0, dev_out_data}, 16'h0034, "R7 busy write ignored");
    repeat (3) tick();
    check({15'h0, dev_out_valid}, 16'h1, "R8 valid held in stall");
    check({8'h0, dev_out_data}, 16'h0034, "R8 data held in stall");
    dev_out_ready = 1'b1;
    tick();
    dev_out_ready = 1'b0;
    check({15'h0, dev_out_valid}, 16'h0, "R8 valid drops after transfer");
    skip_test(CMD_SKIP_OUT, 1'b1, "R4 skip-out free again");

    // R9/R10: interrupt timing
    check({15'h0, irq_o}, 16'h0, "R9 irq off while disabled");
    do_cmd(CMD_IRQ_ON, 16'h0);
    check({15'h0, irq_o}, 16'h0, "R10 irq lags enable");
    tick();
    check({15'h0, irq_o}, 16'h1, "R10 irq for free outbound");
    out_q.push_back(8'h77);
    do_cmd(CMD_WRITE_OUT, 16'hAB77);
    tick();
    check({15'h0, irq_o}, 16'h0, "R10 irq quiet with no flag");
    dev_in_valid = 1'b1; dev_in_data = 8'h5A; in_q.push_back(8'h5A);
    tick();
    dev_in_valid = 1'b0;
    tick();
    check({15'h0, irq_o}, 16'h1, "R10 irq for full inbound");
    do_cmd(CMD_IRQ_OFF, 16'h0);
    tick();
    check({15'h0, irq_o}, 16'h0, "R9 irq cleared by disable");
    dev_out_ready = 1'b1;
    tick();
    dev_out_ready = 1'b0;
    do_cmd(CMD_READ_IN, 16'h0);

    // R6/R8: back-to-back stream with a ready sink
    dev_out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      b = 8'h10 + 8'(i * 37);
      out_q.push_back(b);
      do_cmd(CMD_WRITE_OUT, {8'hEE, b});
      tick();
    end
    dev_out_ready = 1'b0;
    tick();
    check(16'(out_q.size()), 16'h0, "R8 all outbound bytes delivered");
    check(16'(in_q.size()),  16'h0, "R5 all inbound bytes read");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (LIMIT) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule